// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps only the metadata of a configurable set-associative cache: one valid flag, one dirty flag and one tag per line, plus one replacement pointer per set. No data is stored. A requester presents 32-bit load or store requests over a valid/ready handshake. For each accepted request the block splits the address into tag, set index and byte offset. It compares the tag against every way of the indexed set in the same cycle. One cycle later it returns a single-cycle response that reports hit or miss, the set, the way used, and whether a dirty victim had to be written back.

Replacement is a "not most recently used" pointer. After any touch of a way, the pointer moves to the next way up, wrapping around at the top. The cache allocates on writes. Counters run beside the lookup. They track loads, stores, hits, misses and writebacks, and the bytes moving between bus and cache. The bytes out of the cache are counted two ways: as a write-back cache would send them, and as a write-through cache would send them.

Top module: `cache_tag_ctrl`

## Requirements
- R1: With OFF_W = log2(BLOCK_BYTES) and IDX_W = log2(SETS), where SETS = CAPACITY / (BLOCK_BYTES × WAYS), the byte offset is address bits [OFF_W-1:0] and the set index is bits [OFF_W+IDX_W-1:OFF_W]. The tag is the remaining upper bits. `rsp_set` reports the set index.
- R2: After a synchronous active-low reset, every line is invalid and clean with tag zero, and every pointer is 0. All counters read zero, `rsp_valid` is 0 and `req_ready` is 1. The first access to any set misses.
- R3: An access hits exactly when a valid line in the indexed set holds the request tag. Loads and stores hit alike. At most one way matches.
- R4: Every access moves the set's pointer to (touched way + 1) mod WAYS. With 1 way the pointer stays 0, and with 2 ways it names the other way.
- R5: A miss fills the way named by the pointer, even when other ways of the set are invalid. `rsp_way` reports the filled way on a miss and the matching way on a hit.
- R6: A store that misses fills the line (write allocation), so a later access to the same block hits. A store sets the line's single dirty flag.
- R7: `rsp_writeback` is 1 only on a miss whose victim was valid and dirty. A filled line starts dirty only when the filling access is a store.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its response appears as a one-cycle `rsp_valid` pulse right after that edge. With no accepted request, `rsp_valid` is 0.
- R9: `cnt_loads`, `cnt_stores`, `cnt_hits`, `cnt_misses` and `cnt_writebacks` each add one per matching accepted access. They are updated on the accepting edge.
- R10: The byte counters follow these rules:
  - `bytes_in` = misses × BLOCK_BYTES
  - `bytes_out_wb` = writebacks × BLOCK_BYTES
  - `bytes_out_wt` = 4 × stores
  - `bytes_total_wb` = `bytes_in` + `bytes_out_wb`
  - `bytes_total_wt` = `bytes_in` + `bytes_out_wt`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Access hit |
| rsp_set | output | IDX_W | Set index of the access |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_writeback | output | 1 | Dirty victim was evicted |
| cnt_loads | output | CNT_W | Accepted loads |
| cnt_stores | output | CNT_W | Accepted stores |
| cnt_hits | output | CNT_W | Hits |
| cnt_misses | output | CNT_W | Misses |
| cnt_writebacks | output | CNT_W | Writebacks |
| bytes_in | output | BYTE_W | Bus-to-cache bytes |
| bytes_out_wb | output | BYTE_W | Cache-to-bus bytes, write-back |
| bytes_out_wt | output | BYTE_W | Cache-to-bus bytes, write-through |
| bytes_total_wb | output | BYTE_W | Total traffic, write-back |
| bytes_total_wt | output | BYTE_W | Total traffic, write-through |

## Verification
The bench builds the block with 256 B capacity, 16 B blocks and 4 ways, which gives 4 sets. The random trace draws from only six tags per set. That mix makes hits, full sets, pointer wrap-around from way 3 to way 0, dirty evictions and fills past invalid ways all occur many times. Directed accesses first pin down the reset state, write allocation and victim choice while invalid ways remain. A few thousand random loads and stores then cover nearly every reachable state of each small set against a bench model of the same policy.

// File: rtl/cache_tag_pkg.sv
// Shared definitions for the cache tag controller.
// Assumes: all geometry parameters are powers of two.
package cache_tag_pkg;
    localparam int ADDR_BITS = 32;
    localparam int WT_WORD_BYTES = 4;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    // Way-index width: at least one bit so single-way builds stay legal.
    function automatic int way_bits(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction
endpackage

// File: rtl/addr_split.sv
// Splits a byte address into set index and tag fields.
// Assumes: OFF_W + IDX_W < ADDR_W and IDX_W >= 1.
module addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic unused_offset_bits;

    // Field slicing: offset low, index next, tag on top.
    always_comb begin
        unused_offset_bits = ^addr[OFF_W-1:0];
        idx = addr[OFF_W +: IDX_W];
        tag = addr[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/tag_array.sv
// Per-line valid/dirty/tag storage and per-set replacement pointer.
// One combinational read port and one write port that commits on the clock edge.
// Assumes: SETS and WAYS are powers of two.
module tag_array #(
    parameter int SETS  = 8,
    parameter int WAYS  = 2,
    parameter int IDX_W = 3,
    parameter int TAG_W = 24,
    parameter int WAY_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAYS-1:0]            rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAY_W-1:0]           rd_ptr,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic                       wr_dirty,
    input  logic [WAY_W-1:0]           wr_ptr
);
    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0]            dirty_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAY_W-1:0]           ptr_q;

    // Read port: present the indexed set's metadata.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_ptr   = ptr_q[rd_idx];
    end

    // Write port: clear everything on reset, else commit one line and the set pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            tag_q   <= '0;
            ptr_q   <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
            dirty_q[wr_idx][wr_way] <= wr_dirty;
            tag_q[wr_idx][wr_way]   <= wr_tag;
            ptr_q[wr_idx]           <= wr_ptr;
        end
    end

    // R6: a written line reads valid with the written tag afterwards.
    assert_fill_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)][$past(wr_way)] &&
                   tag_q[$past(wr_idx)][$past(wr_way)] == $past(wr_tag)));

    // R7: the dirty flag written is the one presented.
    assert_dirty_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dirty_q[$past(wr_idx)][$past(wr_way)] == $past(wr_dirty)));
endmodule

// File: rtl/way_match.sv
// Parallel tag compare across all ways of one set, with a binary way encode.
// Assumes: the tag array never holds two valid copies of one tag in a set.
module way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 24,
    parameter int WAY_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chk_en,
    input  logic [WAYS-1:0]            line_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            // Per-way comparator.
            assign match[g] = line_valid[g] && (line_tag[g] == req_tag);
        end
    endgenerate

    // Encode the matching way (OR of indices; at most one is set).
    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = hit_way | WAY_W'(w);
        end
    end

    // R3: no set ever holds the request tag in two valid ways.
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $onehot0(match));
endmodule

// File: rtl/traffic_counters.sv
// Access and bus-traffic counters under write-back and write-through accounting.
// Assumes: one update per accepted access; counters wrap at their width.
module traffic_counters #(
    parameter int CNT_W       = 32,
    parameter int BYTE_W      = 48,
    parameter int BLOCK_BYTES = 32,
    parameter int WORD_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              is_store,
    input  logic              hit,
    input  logic              writeback,
    output logic [CNT_W-1:0]  cnt_loads,
    output logic [CNT_W-1:0]  cnt_stores,
    output logic [CNT_W-1:0]  cnt_hits,
    output logic [CNT_W-1:0]  cnt_misses,
    output logic [CNT_W-1:0]  cnt_writebacks,
    output logic [BYTE_W-1:0] bytes_in,
    output logic [BYTE_W-1:0] bytes_out_wb,
    output logic [BYTE_W-1:0] bytes_out_wt,
    output logic [BYTE_W-1:0] bytes_total_wb,
    output logic [BYTE_W-1:0] bytes_total_wt
);
    localparam logic [BYTE_W-1:0] BLK  = BYTE_W'(BLOCK_BYTES);
    localparam logic [BYTE_W-1:0] WORD = BYTE_W'(WORD_BYTES);

    logic [BYTE_W-1:0] in_step, wb_step, wt_step;

    // Per-access byte increments.
    always_comb begin
        in_step = hit ? '0 : BLK;
        wb_step = writeback ? BLK : '0;
        wt_step = is_store ? WORD : '0;
    end

    // Event counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_loads      <= '0;
            cnt_stores     <= '0;
            cnt_hits       <= '0;
            cnt_misses     <= '0;
            cnt_writebacks <= '0;
        end else if (fire) begin
            if (is_store) cnt_stores <= cnt_stores + CNT_W'(1);
            else          cnt_loads  <= cnt_loads + CNT_W'(1);
            if (hit)      cnt_hits   <= cnt_hits + CNT_W'(1);
            else          cnt_misses <= cnt_misses + CNT_W'(1);
            if (writeback) cnt_writebacks <= cnt_writebacks + CNT_W'(1);
        end
    end

    // Byte accumulators; totals accumulate on their own rather than as sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_in       <= '0;
            bytes_out_wb   <= '0;
            bytes_out_wt   <= '0;
            bytes_total_wb <= '0;
            bytes_total_wt <= '0;
        end else if (fire) begin
            bytes_in       <= bytes_in + in_step;
            bytes_out_wb   <= bytes_out_wb + wb_step;
            bytes_out_wt   <= bytes_out_wt + wt_step;
            bytes_total_wb <= bytes_total_wb + in_step + wb_step;
            bytes_total_wt <= bytes_total_wt + in_step + wt_step;
        end
    end

    // R9: every access is one load or store and one hit or miss.
    assert_event_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hits + cnt_misses) == (cnt_loads + cnt_stores));

    // R9: writebacks never outnumber misses.
    assert_wb_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_writebacks <= cnt_misses);

    // R10: totals agree with their parts.
    assert_totals_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bytes_total_wb == bytes_in + bytes_out_wb) &&
        (bytes_total_wt == bytes_in + bytes_out_wt));

    // R10: write-through out-traffic tracks the store count.
    assert_wt_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_out_wt == BYTE_W'(cnt_stores) * WORD);
endmodule

// File: rtl/cache_tag_ctrl.sv
// Metadata-only set-associative cache controller.
// Looks up all ways in one cycle, commits state on the accepting edge and
// returns a one-cycle response.
// Replacement: per-set pointer to (touched way + 1) mod WAYS; write allocation.
// Assumes: CAPACITY, BLOCK_BYTES and WAYS are powers of two, with at least two sets.
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int CAPACITY    = 512,
    parameter int BLOCK_BYTES = 32,
    parameter int WAYS        = 2,
    parameter int CNT_W       = 32,
    parameter int BYTE_W      = 48,
    localparam int LINES = CAPACITY / BLOCK_BYTES,
    localparam int SETS  = LINES / WAYS,
    localparam int OFF_W = $clog2(BLOCK_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_BITS - OFF_W - IDX_W,
    localparam int WAY_W = way_bits(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_set,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_writeback,
    output logic [CNT_W-1:0]  cnt_loads,
    output logic [CNT_W-1:0]  cnt_stores,
    output logic [CNT_W-1:0]  cnt_hits,
    output logic [CNT_W-1:0]  cnt_misses,
    output logic [CNT_W-1:0]  cnt_writebacks,
    output logic [BYTE_W-1:0] bytes_in,
    output logic [BYTE_W-1:0] bytes_out_wb,
    output logic [BYTE_W-1:0] bytes_out_wt,
    output logic [BYTE_W-1:0] bytes_total_wb,
    output logic [BYTE_W-1:0] bytes_total_wt
);
    logic                       ready_q;
    logic                       fire;
    acc_kind_e                  kind;
    logic [IDX_W-1:0]           idx;
    logic [TAG_W-1:0]           tag;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0]            set_dirty;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAY_W-1:0]           set_ptr;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           use_way;
    logic [WAY_W-1:0]           next_ptr;
    logic                       evict_dirty;
    logic                       new_dirty;

    addr_split #(
        .ADDR_W (ADDR_BITS),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) split_i (
        .addr (req_addr),
        .idx  (idx),
        .tag  (tag)
    );

    tag_array #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (set_valid),
        .rd_dirty (set_dirty),
        .rd_tag   (set_tag),
        .rd_ptr   (set_ptr),
        .wr_en    (fire),
        .wr_idx   (idx),
        .wr_way   (use_way),
        .wr_tag   (tag),
        .wr_dirty (new_dirty),
        .wr_ptr   (next_ptr)
    );

    way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) match_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_en     (fire),
        .line_valid (set_valid),
        .line_tag   (set_tag),
        .req_tag    (tag),
        .hit        (hit),
        .hit_way    (hit_way)
    );

    traffic_counters #(
        .CNT_W       (CNT_W),
        .BYTE_W      (BYTE_W),
        .BLOCK_BYTES (BLOCK_BYTES),
        .WORD_BYTES  (WT_WORD_BYTES)
    ) counters_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (fire),
        .is_store       (kind == ACC_STORE),
        .hit            (hit),
        .writeback      (evict_dirty),
        .cnt_loads      (cnt_loads),
        .cnt_stores     (cnt_stores),
        .cnt_hits       (cnt_hits),
        .cnt_misses     (cnt_misses),
        .cnt_writebacks (cnt_writebacks),
        .bytes_in       (bytes_in),
        .bytes_out_wb   (bytes_out_wb),
        .bytes_out_wt   (bytes_out_wt),
        .bytes_total_wb (bytes_total_wb),
        .bytes_total_wt (bytes_total_wt)
    );

    // Pointer advance variant picked by the way count.
    generate
        if (WAYS == 1) begin : g_ptr_dm
            assign next_ptr = '0;
        end else begin : g_ptr_nmru
            assign next_ptr = use_way + WAY_W'(1);
        end
    endgenerate

    // Victim choice, writeback detection and the new dirty value.
    always_comb begin
        kind        = req_write ? ACC_STORE : ACC_LOAD;
        fire        = req_valid && req_ready;
        use_way     = hit ? hit_way : set_ptr;
        evict_dirty = !hit && set_valid[set_ptr] && set_dirty[set_ptr];
        new_dirty   = (kind == ACC_STORE) || (hit && set_dirty[hit_way]);
    end

    // Ready rises on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end
    assign req_ready = ready_q;

    // Response register: one pulse per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_set       <= '0;
            rsp_way       <= '0;
            rsp_writeback <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_hit       <= hit;
                rsp_set       <= idx;
                rsp_way       <= use_way;
                rsp_writeback <= evict_dirty;
            end
        end
    end

    // R8: an accepted request yields a response on the next cycle.
    assert_rsp_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);

    // R8: no response without an accepted request.
    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rsp_valid);

    // R7: writebacks only accompany misses.
    assert_wb_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_writeback) |-> !rsp_hit);

    // R1: the reported set is the index field of the accepted address.
    assert_set_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rsp_set == $past(req_addr[OFF_W +: IDX_W])));
endmodule

// File: tb/cache_tag_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed cases, then a random trace checked against a
// bench model of the replacement and write policies.
module cache_tag_ctrl_tb_top;
    localparam int CAP   = 256;
    localparam int BLK   = 16;
    localparam int NW    = 4;
    localparam int NS    = CAP / (BLK * NW);   // 4 sets
    localparam int OFFB  = 4;
    localparam int IDXB  = 2;
    localparam int TAGB  = 32 - OFFB - IDXB;
    localparam int CW    = 32;
    localparam int BW    = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_writeback;
    logic [IDXB-1:0] rsp_set;
    logic [1:0] rsp_way;
    logic [CW-1:0] cnt_loads, cnt_stores, cnt_hits, cnt_misses, cnt_writebacks;
    logic [BW-1:0] bytes_in, bytes_out_wb, bytes_out_wt, bytes_total_wb, bytes_total_wt;

    always #2 clk = ~clk;   // 250 MHz

    cache_tag_ctrl #(
        .CAPACITY(CAP), .BLOCK_BYTES(BLK), .WAYS(NW), .CNT_W(CW), .BYTE_W(BW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_set(rsp_set), .rsp_way(rsp_way),
        .rsp_writeback(rsp_writeback), .cnt_loads(cnt_loads), .cnt_stores(cnt_stores),
        .cnt_hits(cnt_hits), .cnt_misses(cnt_misses), .cnt_writebacks(cnt_writebacks),
        .bytes_in(bytes_in), .bytes_out_wb(bytes_out_wb), .bytes_out_wt(bytes_out_wt),
        .bytes_total_wb(bytes_total_wb), .bytes_total_wt(bytes_total_wt)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model state.
    bit          mv [NS][NW];
    bit          md [NS][NW];
    int unsigned mt [NS][NW];
    int          mp [NS];
    longint e_ld, e_st, e_hit, e_miss, e_wb;
    bit e_hit_f, e_wb_f;
    int e_way;

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(int unsigned tg, int st, int off);
        return {tg[TAGB-1:0], st[IDXB-1:0], off[OFFB-1:0]};
    endfunction

    task automatic chk_counters();
        chk("R9 loads", cnt_loads, e_ld);
        chk("R9 stores", cnt_stores, e_st);
        chk("R9 hits", cnt_hits, e_hit);
        chk("R9 misses", cnt_misses, e_miss);
        chk("R9 writebacks", cnt_writebacks, e_wb);
        chk("R10 bytes_in", bytes_in, e_miss * BLK);
        chk("R10 out_wb", bytes_out_wb, e_wb * BLK);
        chk("R10 out_wt", bytes_out_wt, e_st * 4);
        chk("R10 total_wb", bytes_total_wb, (e_miss + e_wb) * BLK);
        chk("R10 total_wt", bytes_total_wt, e_miss * BLK + e_st * 4);
    endtask

    // One access: update model, drive at negedge, sample at the following negedge.
    task automatic access(input bit wr, input logic [31:0] a);
        int s;
        int unsigned t;
        s = int'(a[OFFB +: IDXB]);
        t = int'(a[31 -: TAGB]);
        e_hit_f = 1'b0; e_wb_f = 1'b0; e_way = 0;
        for (int w = 0; w < NW; w++)
            if (mv[s][w] && mt[s][w] == t) begin e_hit_f = 1'b1; e_way = w; end
        if (!e_hit_f) begin
            e_way = mp[s];
            e_wb_f = mv[s][e_way] && md[s][e_way];
            md[s][e_way] = wr;
        end else begin
            md[s][e_way] = md[s][e_way] | wr;
        end
        mv[s][e_way] = 1'b1;
        mt[s][e_way] = t;
        mp[s] = (e_way + 1) % NW;
        if (wr) e_st++; else e_ld++;
        if (e_hit_f) e_hit++; else e_miss++;
        if (e_wb_f) e_wb++;

        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 rsp_valid", rsp_valid, 1);
        chk("R3 hit", rsp_hit, e_hit_f);
        chk("R1 set", rsp_set, s);
        chk(e_hit_f ? "R4 way" : "R5 victim way", rsp_way, e_way);
        chk("R7 writeback", rsp_writeback, e_wb_f);
        chk_counters();
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        chk("R8 no pulse when idle", rsp_valid, 0);
    endtask

    // Watchdog.
    initial begin
        #800000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            mp[s] = 0;
            for (int w = 0; w < NW; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0; end
        end
        e_ld = 0; e_st = 0; e_hit = 0; e_miss = 0; e_wb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state at the ports.
        chk("R2 req_ready", req_ready, 1);
        chk("R2 rsp_valid", rsp_valid, 0);
        chk_counters();

        // R2: first access misses into way 0.
        access(1'b0, mk_addr(0, 1, 3));
        chk("R2 first access miss", rsp_hit, 0);
        chk("R4 first victim way 0", rsp_way, 0);
        idle();
        access(1'b0, mk_addr(0, 1, 9));
        chk("R3 load hit same block", rsp_hit, 1);

        // R6: store miss allocates, store makes line dirty.
        access(1'b1, mk_addr(5, 2, 0));
        chk("R6 store miss", rsp_hit, 0);
        access(1'b0, mk_addr(5, 2, 15));
        chk("R6 hit after store allocate", rsp_hit, 1);

        // R5: set 0 ways 0,1 filled, hit way 0 -> pointer 1; miss replaces way 1
        // even though ways 2 and 3 are still invalid.
        access(1'b0, mk_addr(1, 0, 0));
        access(1'b0, mk_addr(2, 0, 0));
        access(1'b0, mk_addr(1, 0, 4));
        access(1'b0, mk_addr(3, 0, 0));
        chk("R5 victim at pointer past invalid ways", rsp_way, 1);

        // R4/R7: fill set 2 (way 0 dirty), wrap pointer, evict dirty way 0.
        access(1'b0, mk_addr(6, 2, 0));
        access(1'b0, mk_addr(7, 2, 0));
        access(1'b0, mk_addr(8, 2, 0));
        access(1'b0, mk_addr(9, 2, 0));
        chk("R4 wrap to way 0", rsp_way, 0);
        chk("R7 dirty victim written back", rsp_writeback, 1);
        access(1'b0, mk_addr(10, 2, 0));
        chk("R7 clean victim no writeback", rsp_writeback, 0);

        // Random trace over a small tag pool.
        for (int i = 0; i < 4000; i++) begin
            access(($urandom % 3) == 0,
                   mk_addr($urandom % 6, int'($urandom % NS), int'($urandom % BLK)));
            if ((i % 500) == 0) idle();
        end
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule